// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

This block runs one processor bus cycle at a time over a set of shared address/data lines. It then rebuilds separate system address, data and command buses from those lines. On the processor side it accepts a request that carries:

- an address;
- a read/write flag;
- a memory/I-O flag;
- a byte-high enable;
- write data.

Each cycle walks through four clock states. The first state puts the address on the shared lines while a latch strobe is high. The second state raises the command. The third state moves data, and can be stretched by a ready input. The fourth state drops every command and data path.

On the system side, a latch fed only from the shared lines holds the address and byte-high enable. A direction/enable pair gates the bidirectional system data bus, and it lets data through only in the data state. A decoder turns the memory/I-O select and the read and write commands into one of four active-low strobes. For a read, the value on the system data bus in the last data state is returned to the processor side with a one-cycle valid flag.

Top module: `mux_bus_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the controller goes idle. After that edge all four strobes are 1, `den_n` is 1, `ale` is 0, `rd_valid` is 0, and `sys_addr` and `sys_bhe_n` are 0. This applies even when reset arrives in the middle of a cycle.
- R2: `req_take` equals `req_valid` when the controller is idle or in the fourth state, and is 0 in the first, second and third states. A taken request starts the first state at the next clock.
- R3: In the first state `ale` is 1 for exactly one clock. `ad_lo` shows address bits [DW-1:0], and `ad_hi` shows `{bhe_n, address[AW-1:DW]}`. `ale` is 0 in every other state.
- R4: `sys_addr`/`sys_bhe_n` take the request address and byte-high enable from the shared lines at the end of the first state. They then hold that value until the end of the next first state. Outside the first and data states, the shared lines carry the bitwise complement of `{bhe_n, address}`. `ad_hi` carries that complement in the data state as well.
- R5: Strobes are the 4-bit group `{mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}`. `req_mem`=1 selects memory and `req_wr`=1 selects write. Exactly one strobe is 0 from the second state through the last data state: 0111 for a memory read, 1011 for a memory write, 1101 for an I/O read and 1110 for an I/O write. All four are 1 in the idle, first and fourth states.
- R6: `den_n` is 0 only in data states. From the first state of a cycle onward, `dt_r` is 1 for a write and 0 for a read.
- R7: In every data state of a write, `sys_data` and `ad_lo` both carry the request write data.
- R8: In every data state of a read, `ad_lo` follows `sys_data`. The value present in the last data state appears on `rd_data`, and `rd_valid` is 1 for exactly the fourth-state clock. `rd_valid` is 0 at all other times.
- R9: If `ready` is 0 at the clock edge that ends a data state, that state repeats. The strobe and `den_n` stay asserted across every repeat, and the fourth state follows the first edge at which `ready` is 1.
- R10: A request taken in the fourth state starts its first state at the very next clock, with no idle clock in between. It shows its new address on `ad_lo` while `sys_addr` still holds the previous address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus state per cycle |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Processor-side cycle request |
| req_addr | input | AW | Request address |
| req_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_bhe_n | input | 1 | Byte-high enable, active low |
| req_wdata | input | DW | Write data |
| req_take | output | 1 | Request accepted this cycle |
| rd_data | output | DW | Read data returned to the processor side |
| rd_valid | output | 1 | One-cycle flag for `rd_data` |
| ready | input | 1 | 0 stretches the data state |
| ad_lo | output | DW | Shared address/data lines |
| ad_hi | output | AW-DW+1 | Shared upper address / status lines, top bit byte-high enable |
| ale | output | 1 | Address latch strobe |
| dt_r | output | 1 | Transceiver direction, 1 = transmit |
| den_n | output | 1 | Transceiver enable, active low |
| sys_addr | output | AW | Latched system address bus |
| sys_bhe_n | output | 1 | Latched byte-high enable |
| sys_data | inout | DW | System data bus |
| mem_rd_n | output | 1 | Memory read strobe |
| mem_wr_n | output | 1 | Memory write strobe |
| io_rd_n | output | 1 | I/O read strobe |
| io_wr_n | output | 1 | I/O write strobe |

## Verification
The bench builds the controller with a 20-bit address and 16-bit data. This leaves a 5-bit upper shared group: four address bits plus the byte-high enable. The checks can therefore see the upper bits, the top bit and the complement filler pass through or be ignored by the latch separately from the low data lines. The vector table covers all four strobe codes, wait counts of zero to three and extreme address patterns. Directed sequences cover back-to-back cycles with a request held high while the controller is busy, and a reset arriving inside a stretched data state.

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl #(
  parameter int AW = 20,
  parameter int DW = 16,
  localparam int HW = AW - DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_mem,
  input  logic          req_wr,
  input  logic          req_bhe_n,
  input  logic [DW-1:0] req_wdata,
  output logic          req_take,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  input  logic          ready,
  output logic [DW-1:0] ad_lo,
  output logic [HW:0]   ad_hi,
  output logic          ale,
  output logic          dt_r,
  output logic          den_n,
  output logic [AW-1:0] sys_addr,
  output logic          sys_bhe_n,
  inout  wire  [DW-1:0] sys_data,
  output logic          mem_rd_n,
  output logic          mem_wr_n,
  output logic          io_rd_n,
  output logic          io_wr_n
);

  typedef enum logic [2:0] {PH_IDLE, PH_ADDR, PH_CMD, PH_DATA, PH_END} phase_t;

  phase_t        ph;
  logic [AW-1:0] a_q;
  logic [DW-1:0] wd_q;
  logic          wr_q, mem_q, bhe_q;
  logic          in_data, in_cmd, cpu_rd_n, cpu_wr_n, rx;
  logic [DW-1:0] cpu_lo;
  logic [HW:0]   cpu_hi;

  assign req_take = req_valid && (ph == PH_IDLE || ph == PH_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= PH_IDLE;
      a_q   <= '0;
      wd_q  <= '0;
      wr_q  <= 1'b0;
      mem_q <= 1'b0;
      bhe_q <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE, PH_END: begin
          if (req_take) begin
            ph    <= PH_ADDR;
            a_q   <= req_addr;
            wd_q  <= req_wdata;
            wr_q  <= req_wr;
            mem_q <= req_mem;
            bhe_q <= req_bhe_n;
          end else begin
            ph <= PH_IDLE;
          end
        end
        PH_ADDR: ph <= PH_CMD;
        PH_CMD:  ph <= PH_DATA;
        PH_DATA: if (ready) ph <= PH_END;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign ale      = (ph == PH_ADDR);
  assign in_data  = (ph == PH_DATA);
  assign in_cmd   = (ph == PH_CMD) || in_data;
  assign cpu_rd_n = !(in_cmd && !wr_q);
  assign cpu_wr_n = !(in_cmd && wr_q);
  assign dt_r     = wr_q;
  assign den_n    = !in_data;
  assign rx       = in_data && !wr_q;

  always_comb begin
    if (ale) begin
      cpu_lo = a_q[DW-1:0];
      cpu_hi = {bhe_q, a_q[AW-1:DW]};
    end else begin
      cpu_lo = (in_data && wr_q) ? wd_q : ~a_q[DW-1:0];
      cpu_hi = ~{bhe_q, a_q[AW-1:DW]};
    end
  end

  assign ad_lo = rx ? sys_data : cpu_lo;
  assign ad_hi = cpu_hi;

  assign sys_data = (!den_n && dt_r) ? cpu_lo : {DW{1'bz}};

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_addr  <= '0;
      sys_bhe_n <= 1'b0;
    end else if (ale) begin
      {sys_bhe_n, sys_addr} <= {ad_hi, ad_lo};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rx && ready;
      if (rx && ready) rd_data <= ad_lo;
    end
  end

  assign mem_rd_n = !( mem_q && !cpu_rd_n);
  assign mem_wr_n = !( mem_q && !cpu_wr_n);
  assign io_rd_n  = !(!mem_q && !cpu_rd_n);
  assign io_wr_n  = !(!mem_q && !cpu_wr_n);

endmodule

// File: rtl/mux_bus_ctrl_chk.sv
module mux_bus_ctrl_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst,
  input logic          ready,
  input logic          req_take,
  input logic          ale,
  input logic          dt_r,
  input logic          den_n,
  input logic          rd_valid,
  input logic [AW-1:0] sys_addr,
  input logic          sys_bhe_n,
  input logic          mem_rd_n,
  input logic          mem_wr_n,
  input logic          io_rd_n,
  input logic          io_wr_n
);

  logic [3:0] strb;
  assign strb = {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n};

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $countones(~strb) <= 1); // R5

  AST_TAKE_WHEN_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_take |-> (strb == 4'hF && den_n && !ale)); // R2

  AST_ALE_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale); // R3

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !$past(ale) |-> ($stable(sys_addr) && $stable(sys_bhe_n))); // R4

  AST_DEN_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
    !den_n |-> strb != 4'hF); // R6

  AST_WRITE_DIRECTION: assert property (@(posedge clk) disable iff (rst)
    (!mem_wr_n || !io_wr_n) |-> dt_r); // R6

  AST_RDV_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid); // R8

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!den_n && !ready) |=> (!den_n && $stable(strb))); // R9

endmodule

bind mux_bus_ctrl mux_bus_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .ready(ready), .req_take(req_take), .ale(ale),
  .dt_r(dt_r), .den_n(den_n), .rd_valid(rd_valid), .sys_addr(sys_addr),
  .sys_bhe_n(sys_bhe_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
  .io_rd_n(io_rd_n), .io_wr_n(io_wr_n)
);

// File: tb/mux_bus_ctrl_bench.sv
module mux_bus_ctrl_bench;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        mem;
    logic        wr;
    logic        bhe;
    logic [19:0] addr;
    logic [15:0] wd;
    logic [15:0] rsp;
    logic [3:0]  waits;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 1'b0, 1'b0, 20'hF1234, 16'h0000, 16'hCAFE, 4'd0},
    '{1'b1, 1'b1, 1'b1, 20'h0A5C3, 16'h1357, 16'h0000, 4'd0},
    '{1'b0, 1'b0, 1'b0, 20'h00F0F, 16'h0000, 16'h8001, 4'd2},
    '{1'b0, 1'b1, 1'b1, 20'h9ABCD, 16'hA5A5, 16'h0000, 4'd1},
    '{1'b1, 1'b1, 1'b0, 20'hFFFFF, 16'hFFFF, 16'h0000, 4'd3},
    '{1'b1, 1'b0, 1'b1, 20'h00000, 16'h0000, 16'hFFFF, 4'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_mem = 1'b0;
  logic req_wr = 1'b0;
  logic req_bhe_n = 1'b1;
  logic [DW-1:0] req_wdata = '0;
  logic ready = 1'b1;
  logic req_take, rd_valid, ale, dt_r, den_n, sys_bhe_n;
  logic mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;
  logic [DW-1:0] rd_data, ad_lo;
  logic [AW-DW:0] ad_hi;
  logic [AW-1:0] sys_addr;
  wire  [DW-1:0] sys_data;
  logic mem_drv = 1'b0;
  logic [DW-1:0] mem_val = '0;
  logic [3:0] strb;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  assign sys_data = mem_drv ? mem_val : {DW{1'bz}};
  assign strb = {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n};

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_ctrl #(.AW(AW), .DW(DW)) u_mux_bus_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_mem(req_mem), .req_wr(req_wr), .req_bhe_n(req_bhe_n),
    .req_wdata(req_wdata), .req_take(req_take), .rd_data(rd_data),
    .rd_valid(rd_valid), .ready(ready), .ad_lo(ad_lo), .ad_hi(ad_hi),
    .ale(ale), .dt_r(dt_r), .den_n(den_n), .sys_addr(sys_addr),
    .sys_bhe_n(sys_bhe_n), .sys_data(sys_data), .mem_rd_n(mem_rd_n),
    .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] strb_exp(input logic mem, input logic wr);
    case ({mem, wr})
      2'b10:   return 4'b0111;
      2'b11:   return 4'b1011;
      2'b00:   return 4'b1101;
      default: return 4'b1110;
    endcase
  endfunction

  task automatic set_req(input logic mem, input logic wr, input logic bhe,
                         input logic [19:0] addr, input logic [15:0] wd);
    req_valid = 1'b1; req_mem = mem; req_wr = wr; req_bhe_n = bhe;
    req_addr = addr; req_wdata = wd;
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    set_req(v.mem, v.wr, v.bhe, v.addr, v.wd);
    #1;
    chk("R2 take from idle", {31'b0, req_take}, 32'd1);
    chk("R8 valid low in idle", {31'b0, rd_valid}, 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk("R3 ale in first state", {31'b0, ale}, 32'd1);
    chk("R3 low lines carry address", {16'b0, ad_lo}, {16'b0, v.addr[15:0]});
    chk("R3 high lines carry bhe+address", {27'b0, ad_hi}, {27'b0, v.bhe, v.addr[19:16]});
    chk("R5 no strobe in first state", {28'b0, strb}, 32'hF);
    chk("R6 den off in first state", {31'b0, den_n}, 32'd1);
    chk("R2 no take while busy", {31'b0, req_take}, 32'd0);
    @(negedge clk);
    if (!v.wr) begin mem_drv = 1'b1; mem_val = v.rsp; end
    #1;
    chk("R4 latched address", {12'b0, sys_addr}, {12'b0, v.addr});
    chk("R4 latched bhe", {31'b0, sys_bhe_n}, {31'b0, v.bhe});
    chk("R4 filler on low lines", {16'b0, ad_lo}, {16'b0, ~v.addr[15:0]});
    chk("R3 ale low after first state", {31'b0, ale}, 32'd0);
    chk("R5 strobe in second state", {28'b0, strb}, {28'b0, strb_exp(v.mem, v.wr)});
    chk("R6 den off in second state", {31'b0, den_n}, 32'd1);
    chk("R6 direction", {31'b0, dt_r}, {31'b0, v.wr});
    for (int w = 0; w <= int'(v.waits); w++) begin
      @(negedge clk);
      ready = (w == int'(v.waits));
      #1;
      chk(w > 0 ? "R9 den held in wait" : "R6 den on in data state", {31'b0, den_n}, 32'd0);
      chk(w > 0 ? "R9 strobe held in wait" : "R5 strobe in data state",
          {28'b0, strb}, {28'b0, strb_exp(v.mem, v.wr)});
      chk("R4 latch stable in data state", {12'b0, sys_addr}, {12'b0, v.addr});
      chk("R4 high lines not address", {27'b0, ad_hi}, {27'b0, ~{v.bhe, v.addr[19:16]}});
      if (v.wr) begin
        chk("R7 write data on system bus", {16'b0, sys_data}, {16'b0, v.wd});
        chk("R7 write data on shared lines", {16'b0, ad_lo}, {16'b0, v.wd});
      end else begin
        chk("R8 read data on shared lines", {16'b0, ad_lo}, {16'b0, v.rsp});
      end
    end
    @(negedge clk);
    ready = 1'b1; mem_drv = 1'b0;
    #1;
    chk("R5 strobes off in fourth state", {28'b0, strb}, 32'hF);
    chk("R6 den off in fourth state", {31'b0, den_n}, 32'd1);
    chk("R8 valid in fourth state", {31'b0, rd_valid}, {31'b0, !v.wr});
    if (!v.wr) chk("R8 read data returned", {16'b0, rd_data}, {16'b0, v.rsp});
    chk("R4 latch holds in fourth state", {12'b0, sys_addr}, {12'b0, v.addr});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset strobes", {28'b0, strb}, 32'hF);
    chk("R1 reset den", {31'b0, den_n}, 32'd1);
    chk("R1 reset ale", {31'b0, ale}, 32'd0);
    chk("R1 reset latch", {11'b0, sys_bhe_n, sys_addr}, 32'd0);
    chk("R1 reset valid", {31'b0, rd_valid}, 32'd0);
    rst = 1'b0;

    foreach (VECS[i]) run_vec(VECS[i]);

    // R2 / R10: request held while busy, then taken in the fourth state
    @(negedge clk);
    set_req(1'b1, 1'b1, 1'b0, 20'h12345, 16'hBEEF);
    #1 chk("R2 take A", {31'b0, req_take}, 32'd1);
    @(negedge clk);
    set_req(1'b0, 1'b0, 1'b1, 20'h0ABCD, 16'h0000);
    #1;
    chk("R2 no take in first state", {31'b0, req_take}, 32'd0);
    chk("R3 A address out", {16'b0, ad_lo}, 32'h2345);
    @(negedge clk);
    #1;
    chk("R2 no take in second state", {31'b0, req_take}, 32'd0);
    chk("R4 A latched", {12'b0, sys_addr}, 32'h12345);
    @(negedge clk);
    #1;
    chk("R2 no take in data state", {31'b0, req_take}, 32'd0);
    chk("R7 A write data", {16'b0, sys_data}, 32'hBEEF);
    @(negedge clk);
    #1;
    chk("R10 take in fourth state", {31'b0, req_take}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk("R10 B first state at once", {31'b0, ale}, 32'd1);
    chk("R10 B address out", {16'b0, ad_lo}, 32'hABCD);
    chk("R10 latch still A", {12'b0, sys_addr}, 32'h12345);
    @(negedge clk);
    mem_drv = 1'b1; mem_val = 16'h5A5A;
    #1;
    chk("R10 B latched", {11'b0, sys_bhe_n, sys_addr}, {11'b0, 1'b1, 20'h0ABCD});
    chk("R5 io read strobe", {28'b0, strb}, 32'hD);
    @(negedge clk);
    @(negedge clk);
    mem_drv = 1'b0;
    #1 chk("R8 B read data", {16'b0, rd_data}, 32'h5A5A);

    // R1: reset inside a stretched data state
    @(negedge clk);
    set_req(1'b0, 1'b1, 1'b0, 20'h33333, 16'h4444);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    ready = 1'b0;
    #1 chk("R9 data state reached", {31'b0, den_n}, 32'd0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    #1;
    chk("R1 mid-cycle reset strobes", {28'b0, strb}, 32'hF);
    chk("R1 mid-cycle reset den", {31'b0, den_n}, 32'd1);
    chk("R1 mid-cycle reset latch", {11'b0, sys_bhe_n, sys_addr}, 32'd0);
    chk("R1 mid-cycle reset ale", {31'b0, ale}, 32'd0);
    rst = 1'b0; ready = 1'b1;
    @(negedge clk);
    #1 chk("R1 stays idle after reset", {28'b0, strb}, 32'hF);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule